// File: doc/BRIEF.md
# SYSREF Divider and Delay-Code Generator

This block runs on the input clock and produces the SYSREF strobe. In the two generator modes a prescaler (divide by 1, 2 or 4) drives a main divider. The output is a square wave whose total period is N = prescale × main divide input-clock cycles. In continuous mode the wave runs freely. In pulser mode a rising edge on the request input releases a programmed burst of whole periods, and the output then stays low. In repeater mode the request input is retimed by one register and passed to the output. The bypass select output tells the downstream path which of the two routes is active.

The logic cannot measure frequency, so the input-clock band comes in as a 3-bit code. From this code the block derives two values for the analog phase interpolator: its divide value and its scale code. It also checks the prescale and divide settings against the band and against the interpolator divide value, and raises a registered error flag when a generator-mode setting is illegal. A separate path turns a quadrant code and a 7-bit I or Q fine value into a linear step number on a 508-step scale.

Top module: `sysref_gen`

## Requirements
- R1: `step_o` is 127−I for quadrant 3, 254−Q for quadrant 2, 381−I for quadrant 0 and 508−Q for quadrant 1, where I is `dly_i_i` and Q is `dly_q_i`; it is combinational.
- R2: Band codes: 0 is 0.3–0.4 GHz, 1 is 0.4–0.8 GHz, 2 is 0.8–1.6 GHz, 3 is 1.6–3.2 GHz, 4 is 3.2–6.4 GHz and 5 is 6.4–12.8 GHz. For these codes `interp_div_o` is 2, 2, 2, 4, 8 and 16, and `scale_o` is 2, 1, 0, 0, 0 and 0. Codes 6 and 7 give a divide value of 0, a scale of 0, and an error in a generator mode.
- R3: `pre_i` codes 0, 1 and 2 select divide by 1, 2 and 4, and code 3 is illegal. Band 4 needs a prescale of 2 or 4, and band 5 needs a prescale of 4.
- R4: The total divide N = prescale × `div_i` must lie in 2..16380, with a minimum of 4 in band 4 and 8 in band 5.
- R5: In a generator mode, N must be an integer multiple of `interp_div_o`.
- R6: `cfg_err_o` is registered. One cycle after a generator mode (0 continuous, 1 pulser) with a setting that breaks R2–R5, it is 1. Mode 3 also gives 1. Mode 2 (repeater) gives 0.
- R7: In continuous mode `sysref_o` has a period of N cycles and is high for the first floor(N/2) cycles of each period.
- R8: New prescale and divide values take effect only at the end of a full period, and only if they are legal. Otherwise the previous values keep running.
- R9: In pulser mode, each rising edge of `req_i` causes `pcnt_i`+1 whole pulses starting at the next period boundary, and `sysref_o` then stays low.
- R10: In repeater mode `sysref_o` equals `req_i` one cycle later, and `byp_o` is 1. In the other modes `byp_o` is 0.
- R11: Mode 3 is reserved and holds `sysref_o` low.
- R12: During reset `sysref_o` and `cfg_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | input clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| band_i | input | 3 | input-frequency band code |
| mode_i | input | 2 | 0 continuous, 1 pulser, 2 repeater, 3 reserved |
| pre_i | input | 2 | prescaler select |
| div_i | input | 14 | main divide value |
| pcnt_i | input | 4 | pulser burst length minus one |
| req_i | input | 1 | SYSREF request |
| dly_quad_i | input | 2 | delay quadrant code |
| dly_i_i | input | 7 | in-phase fine setting |
| dly_q_i | input | 7 | quadrature fine setting |
| sysref_o | output | 1 | SYSREF strobe |
| byp_o | output | 1 | delay path bypass select |
| step_o | output | 9 | linear delay step number |
| interp_div_o | output | 5 | interpolator divide value |
| scale_o | output | 2 | interpolator scale code |
| cfg_err_o | output | 1 | illegal configuration flag |

## Verification
The assertions check on every cycle that the repeater retimes the request, that the reserved mode stays low and flagged, that the repeater never raises the error flag, and that a non-zero scale code always comes with an interpolator divide value of 2. The bench scenarios are needed for period and duty cycle, for reload only at the period boundary, for holding an illegal setting off, for the burst count after a request edge, and for the step-number and band-table values.

// File: rtl/sysref_pkg.sv
`timescale 1ns/1ps
package sysref_pkg;
  typedef enum logic [1:0] {
    MODE_CONT   = 2'd0,
    MODE_PULSE  = 2'd1,
    MODE_REPEAT = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  localparam logic [2:0] BAND_MAX = 3'd5;
endpackage

// File: rtl/sysref_cfg_check.sv
`timescale 1ns/1ps
module sysref_cfg_check #(
  parameter int MAIN_W = 14,
  parameter int N_MAX  = 16380,
  localparam int TOT_W = MAIN_W + 2
) (
  input  logic [2:0]        band_i,
  input  logic [1:0]        pre_i,
  input  logic [MAIN_W-1:0] div_i,
  output logic [4:0]        interp_div_o,
  output logic [1:0]        scale_o,
  output logic              legal_o
);
  import sysref_pkg::*;

  logic [TOT_W-1:0] n_tot, d_ext, n_min;
  logic band_ok, pre_ok, range_ok, mult_ok;

  always_comb begin
    interp_div_o = 5'd0;
    scale_o      = 2'd0;
    case (band_i)
      3'd0: begin interp_div_o = 5'd2;  scale_o = 2'd2; end
      3'd1: begin interp_div_o = 5'd2;  scale_o = 2'd1; end
      3'd2: interp_div_o = 5'd2;
      3'd3: interp_div_o = 5'd4;
      3'd4: interp_div_o = 5'd8;
      3'd5: interp_div_o = 5'd16;
      default: ;
    endcase
  end

  always_comb begin
    n_tot    = {2'b00, div_i} << pre_i;
    d_ext    = TOT_W'(interp_div_o);
    band_ok  = band_i <= BAND_MAX;
    pre_ok   = (pre_i != 2'd3) &&
               ((band_i <= 3'd3) ||
                (band_i == 3'd4 && pre_i != 2'd0) ||
                (band_i == 3'd5 && pre_i == 2'd2));
    n_min    = (band_i == 3'd5) ? TOT_W'(8) : (band_i == 3'd4) ? TOT_W'(4) : TOT_W'(2);
    range_ok = (n_tot >= n_min) && (n_tot <= TOT_W'(N_MAX));
    mult_ok  = (d_ext != '0) && ((n_tot & (d_ext - TOT_W'(1))) == '0);
    legal_o  = band_ok && pre_ok && range_ok && mult_ok;
  end
endmodule

// File: rtl/sysref_divider.sv
`timescale 1ns/1ps
module sysref_divider #(
  parameter int MAIN_W = 14,
  localparam int TOT_W = MAIN_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        pre_i,
  input  logic [MAIN_W-1:0] div_i,
  input  logic              load_ok_i,
  output logic              period_end_o,
  output logic              high_o
);
  logic [1:0]        ps_q, p_q, p_lim;
  logic [MAIN_W-1:0] m_q, c_q;
  logic [TOT_W-1:0]  pos, half;
  logic              tick;

  always_comb begin
    case (ps_q)
      2'd0:    p_lim = 2'd0;
      2'd1:    p_lim = 2'd1;
      default: p_lim = 2'd3;
    endcase
    tick         = (p_q == p_lim);
    period_end_o = tick && (c_q == m_q - MAIN_W'(1));
    pos          = ({2'b00, c_q} << ps_q) + TOT_W'(p_q);
    half         = ({2'b00, m_q} << ps_q) >> 1;
    high_o       = pos < half;
  end

  // both stages restart and reload together at the full-period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q <= 2'd0;
      m_q  <= MAIN_W'(1);
      p_q  <= 2'd0;
      c_q  <= '0;
    end else if (period_end_o) begin
      p_q <= 2'd0;
      c_q <= '0;
      if (load_ok_i) begin
        ps_q <= pre_i;
        m_q  <= div_i;
      end
    end else if (tick) begin
      p_q <= 2'd0;
      c_q <= c_q + MAIN_W'(1);
    end else begin
      p_q <= p_q + 2'd1;
    end
  end
endmodule

// File: rtl/sysref_dly_step.sv
`timescale 1ns/1ps
module sysref_dly_step #(
  parameter int FINE_W = 7,
  localparam int STEP_W = FINE_W + 2,
  localparam int QSPAN  = (1 << FINE_W) - 1
) (
  input  logic [1:0]        quad_i,
  input  logic [FINE_W-1:0] fine_i_i,
  input  logic [FINE_W-1:0] fine_q_i,
  output logic [STEP_W-1:0] step_o
);
  logic [STEP_W-1:0] ii, qq;

  always_comb begin
    ii = STEP_W'(fine_i_i);
    qq = STEP_W'(fine_q_i);
    case (quad_i)
      2'd3:    step_o = STEP_W'(QSPAN)     - ii;
      2'd2:    step_o = STEP_W'(2 * QSPAN) - qq;
      2'd0:    step_o = STEP_W'(3 * QSPAN) - ii;
      default: step_o = STEP_W'(4 * QSPAN) - qq;
    endcase
  end
endmodule

// File: rtl/sysref_gen.sv
`timescale 1ns/1ps
module sysref_gen #(
  parameter int MAIN_W = 14,
  parameter int N_MAX  = 16380,
  parameter int PCNT_W = 4,
  parameter int FINE_W = 7,
  localparam int STEP_W = FINE_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        band_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        pre_i,
  input  logic [MAIN_W-1:0] div_i,
  input  logic [PCNT_W-1:0] pcnt_i,
  input  logic              req_i,
  input  logic [1:0]        dly_quad_i,
  input  logic [FINE_W-1:0] dly_i_i,
  input  logic [FINE_W-1:0] dly_q_i,
  output logic              sysref_o,
  output logic              byp_o,
  output logic [STEP_W-1:0] step_o,
  output logic [4:0]        interp_div_o,
  output logic [1:0]        scale_o,
  output logic              cfg_err_o
);
  import sysref_pkg::*;

  mode_e mode;
  logic legal, period_end, div_high, req_q, armed_q, rise, err_d, out_d;
  logic [PCNT_W:0] rem_q;

  assign mode  = mode_e'(mode_i);
  assign byp_o = (mode == MODE_REPEAT);
  assign rise  = req_i && !req_q;

  sysref_cfg_check #(.MAIN_W(MAIN_W), .N_MAX(N_MAX)) u_cfg (
    .band_i(band_i), .pre_i(pre_i), .div_i(div_i),
    .interp_div_o(interp_div_o), .scale_o(scale_o), .legal_o(legal)
  );

  sysref_divider #(.MAIN_W(MAIN_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .pre_i(pre_i), .div_i(div_i),
    .load_ok_i(legal), .period_end_o(period_end), .high_o(div_high)
  );

  sysref_dly_step #(.FINE_W(FINE_W)) u_step (
    .quad_i(dly_quad_i), .fine_i_i(dly_i_i), .fine_q_i(dly_q_i), .step_o(step_o)
  );

  always_comb begin
    case (mode)
      MODE_CONT:   begin out_d = div_high;                   err_d = !legal; end
      MODE_PULSE:  begin out_d = div_high && (rem_q != '0);  err_d = !legal; end
      MODE_REPEAT: begin out_d = req_i;                      err_d = 1'b0;   end
      default:     begin out_d = 1'b0;                       err_d = 1'b1;   end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= 1'b0;
      armed_q   <= 1'b0;
      rem_q     <= '0;
      sysref_o  <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      req_q     <= req_i;
      sysref_o  <= out_d;
      cfg_err_o <= err_d;
      if (mode != MODE_PULSE) begin
        armed_q <= 1'b0;
        rem_q   <= '0;
      end else begin
        // burst starts only on a period boundary so pulses are whole
        if (period_end && armed_q) begin
          rem_q   <= (PCNT_W+1)'(pcnt_i) + (PCNT_W+1)'(1);
          armed_q <= rise;
        end else begin
          if (rise) armed_q <= 1'b1;
          if (period_end && rem_q != '0) rem_q <= rem_q - (PCNT_W+1)'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sysref_gen_chk.sv
`timescale 1ns/1ps
module sysref_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       req_i,
  input logic       sysref_o,
  input logic       cfg_err_o,
  input logic [4:0] interp_div_o,
  input logic [1:0] scale_o
);
  a_r10_repeat_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |=> (sysref_o == $past(req_i)));

  a_r6_repeat_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |=> !cfg_err_o);

  a_r11_rsvd_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |=> !sysref_o);

  a_r6_rsvd_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |=> cfg_err_o);

  a_r2_scale_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scale_o != 2'd0) |-> (interp_div_o == 5'd2));
endmodule

bind sysref_gen sysref_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .req_i(req_i),
  .sysref_o(sysref_o), .cfg_err_o(cfg_err_o),
  .interp_div_o(interp_div_o), .scale_o(scale_o)
);

// File: tb/sysref_gen_tb.sv
`timescale 1ns/1ps
module sysref_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] band = 3'd2;
  logic [1:0] mode = 2'd0, pre = 2'd0, quad = 2'd0;
  logic [13:0] div = 14'd6;
  logic [3:0] pcnt = 4'd0;
  logic req = 1'b0;
  logic [6:0] fi = '0, fq = '0;
  logic sysref, byp, cfg_err;
  logic [8:0] step;
  logic [4:0] idiv;
  logic [1:0] scale;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sysref_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .band_i(band), .mode_i(mode), .pre_i(pre),
    .div_i(div), .pcnt_i(pcnt), .req_i(req), .dly_quad_i(quad), .dly_i_i(fi),
    .dly_q_i(fq), .sysref_o(sysref), .byp_o(byp), .step_o(step),
    .interp_div_o(idiv), .scale_o(scale), .cfg_err_o(cfg_err)
  );

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 sysref in reset", sysref, 0);
    chk("R12 err in reset", cfg_err, 0);
    rst_n = 1'b1;
  endtask

  task automatic setcfg(logic [2:0] b, logic [1:0] p, int d, logic [1:0] m);
    band = b; pre = p; div = 14'(d); mode = m;
  endtask

  task automatic wait_rise();
    logic prev = sysref;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sysref && !prev) return;
      prev = sysref;
    end
  endtask

  task automatic run_len(logic v, output int n);
    n = 0;
    while (sysref == v && n < 400) begin n++; @(negedge clk); end
  endtask

  task automatic count_rises(int cyc, output int n);
    logic prev = sysref;
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (sysref && !prev) n++;
      prev = sysref;
    end
  endtask

  task automatic t_step();
    quad = 2'd3; fi = 7'd0;   #1 chk("R1 q3 I0", step, 127);
    fi = 7'd127;              #1 chk("R1 q3 I127", step, 0);
    quad = 2'd2; fq = 7'd10;  #1 chk("R1 q2 Q10", step, 244);
    quad = 2'd0; fi = 7'd127; #1 chk("R1 q0 I127", step, 254);
    quad = 2'd1; fq = 7'd0;   #1 chk("R1 q1 Q0", step, 508);
  endtask

  task automatic t_interp();
    band = 3'd5; #1 chk("R2 b5 div", idiv, 16); chk("R2 b5 scale", scale, 0);
    band = 3'd4; #1 chk("R2 b4 div", idiv, 8);
    band = 3'd3; #1 chk("R2 b3 div", idiv, 4);
    band = 3'd1; #1 chk("R2 b1 div", idiv, 2); chk("R2 b1 scale", scale, 1);
    band = 3'd0; #1 chk("R2 b0 div", idiv, 2); chk("R2 b0 scale", scale, 2);
    band = 3'd7; #1 chk("R2 b7 div", idiv, 0);
  endtask

  task automatic legal_case(string r, logic [2:0] b, logic [1:0] p, int d, int exp);
    @(negedge clk); setcfg(b, p, d, 2'd0);
    @(negedge clk); chk(r, cfg_err, exp);
  endtask

  task automatic t_legal();
    legal_case("R2 band6 err", 3'd6, 2'd0, 6, 1);
    legal_case("R3 b5 pre2x err", 3'd5, 2'd1, 8, 1);
    legal_case("R3 b5 pre4x ok", 3'd5, 2'd2, 4, 0);
    legal_case("R3 b4 pre1x err", 3'd4, 2'd0, 8, 1);
    legal_case("R3 pre code3 err", 3'd2, 2'd3, 4, 1);
    legal_case("R4 over max err", 3'd2, 2'd2, 4096, 1);
    legal_case("R4 at max ok", 3'd2, 2'd2, 4095, 0);
    legal_case("R4 zero err", 3'd1, 2'd0, 0, 1);
    legal_case("R4 b4 N2 err", 3'd4, 2'd1, 1, 1);
    legal_case("R5 N6 D4 err", 3'd3, 2'd0, 6, 1);
    legal_case("R5 N8 D4 ok", 3'd3, 2'd0, 8, 0);
    legal_case("R5 N24 D16 err", 3'd5, 2'd2, 6, 1);
    legal_case("R4 min N2 ok", 3'd2, 2'd1, 1, 0);
  endtask

  task automatic t_cont();
    int hi, lo;
    setcfg(3'd2, 2'd0, 6, 2'd0);
    do_reset();
    wait_rise(); run_len(1'b1, hi); run_len(1'b0, lo);
    chk("R7 N6 high", hi, 3); chk("R7 N6 low", lo, 3);
    chk("R10 byp gen", byp, 0);
    setcfg(3'd4, 2'd1, 4, 2'd0);
    repeat (20) @(negedge clk);
    wait_rise(); run_len(1'b1, hi); run_len(1'b0, lo);
    chk("R7 N8 high", hi, 4); chk("R7 N8 low", lo, 4);
  endtask

  task automatic t_reload();
    int hi, lo;
    wait_rise();
    div = 14'd8;
    run_len(1'b1, hi); run_len(1'b0, lo);
    chk("R8 old high kept", hi, 4); chk("R8 old low kept", lo, 4);
    run_len(1'b1, hi); run_len(1'b0, lo);
    chk("R8 new high", hi, 8); chk("R8 new low", lo, 8);
    div = 14'd3;
    repeat (3) @(negedge clk);
    chk("R6 err illegal", cfg_err, 1);
    repeat (20) @(negedge clk);
    wait_rise(); run_len(1'b1, hi); run_len(1'b0, lo);
    chk("R8 illegal not loaded hi", hi, 8); chk("R8 illegal not loaded lo", lo, 8);
  endtask

  task automatic t_pulse();
    int n;
    setcfg(3'd2, 2'd0, 6, 2'd1); pcnt = 4'd2;
    repeat (40) @(negedge clk);
    count_rises(20, n); chk("R9 idle no pulses", n, 0);
    req = 1'b1;
    count_rises(60, n); chk("R9 burst of 3", n, 3);
    req = 1'b0;
    count_rises(40, n); chk("R9 low after burst", n, 0);
    pcnt = 4'd0; req = 1'b1;
    count_rises(40, n); chk("R9 burst of 1", n, 1);
    req = 1'b0;
  endtask

  task automatic t_repeat();
    logic pat [5] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    setcfg(3'd2, 2'd0, 0, 2'd2);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      req = pat[i];
      @(negedge clk);
      chk("R10 repeat follow", sysref, int'(pat[i]));
    end
    chk("R10 byp repeat", byp, 1);
    chk("R6 no err repeat", cfg_err, 0);
  endtask

  task automatic t_rsvd();
    int n = 0;
    mode = 2'd3; req = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sysref) n++;
    end
    chk("R11 rsvd low", n, 0);
    chk("R6 rsvd err", cfg_err, 1);
    req = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_step();
    t_interp();
    t_legal();
    t_cont();
    t_reload();
    t_pulse();
    t_repeat();
    t_rsvd();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule